// File: doc/BRIEF.md
# Second-strobe frequency deviation averager

This block disciplines a local reference oscillator against a once-per-second timing strobe. It counts reference-clock cycles between consecutive strobes and subtracts the nominal count to get the error for each second. A second whose error lies outside a ±128-count window is discarded. Each group of three accepted errors is summed and divided by three to form one average.

The average is held as a signed correction word. During the following control period the block issues a valid pulse with that word after every strobe, so a downstream converter driver can steer the oscillator once per second. If no strobe arrives within one and a half nominal periods, a missing-pulse flag is raised and the unfinished second is dropped. The held correction stays in place.

The strobe is assumed to be already qualified and one clock cycle wide. Strobes are assumed to be at least five cycles apart.

Top module: `pps_dev_avg`

## Requirements
- R1: While reset is asserted, and until the first average exists, `corr_valid_o`, `reject_o`, `missing_o` and `avg_ready_o` are 0 and `corr_word_o` is 0.
- R2: The first strobe after reset, and the first strobe after a missing-pulse event, only starts period counting. It yields no deviation sample and raises no reject.
- R3: The period is the number of clock cycles from one strobe cycle to the next. Its deviation is the period minus `NOMINAL`. A deviation in the range -128..127 inclusive is accepted. Deviations of +128 or -129 and beyond are refused.
- R4: A refused second raises `reject_o` for exactly one cycle, two cycles after the closing strobe. It does not enter the average.
- R5: After every third accepted deviation, `corr_word_o` becomes their sum divided by 3. The word is an 8-bit two's-complement value. It is visible three cycles after the strobe that closed the third second.
- R6: Once `avg_ready_o` is 1, every strobe produces a one-cycle `corr_valid_o` pulse three cycles later, carrying the held average. Before the first average there is no pulse.
- R7: If no strobe arrives while the cycle count since the last strobe reaches `NOMINAL + NOMINAL/2`, then `missing_o` rises in the next cycle. It stays high until the next strobe, which clears it in the following cycle. The held average and the deviations already accumulated toward the current group are kept.
- R8: The division truncates toward zero for negative sums: a sum of -2 gives 0, and a sum of -4 gives -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock being disciplined |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_i | input | 1 | Qualified one-cycle second strobe |
| corr_word_o | output | 8 | Held average deviation, two's complement |
| corr_valid_o | output | 1 | One-cycle pulse presenting the correction word |
| avg_ready_o | output | 1 | An average has been formed since reset |
| reject_o | output | 1 | One-cycle pulse for an out-of-window second |
| missing_o | output | 1 | Strobe overdue; held until the next strobe |

## Verification
The bench places seconds exactly on both edges of the acceptance window: +127 and -128 are accepted, while +128 and -129 are refused. A design that compared only the low eight bits, or that used an off-by-one bound, would refuse or average the wrong seconds. That error would shift a later correction word.

Groups that sum to -2, -4, -384 and +381 test the divider. A floor divider would give -1 and -2 for the first two, and a poor reciprocal would miss the extremes.

Timeout handling is checked on the exact cycle the flag rises. The bench also checks that the restarting strobe adds no sample and that the partial group survives the timeout. A design that measured a sample from the restarting strobe would misalign the group and report a different average.

// File: rtl/pps_avg_pkg.sv
package pps_avg_pkg;
  localparam int DEV_W = 8;
  localparam int ACC_W = 10;
  localparam int DEV_MIN = -128;
  localparam int DEV_MAX = 127;
  localparam int RECIP = 171;   // 171/512 approximates 1/3 exactly for |s| <= 384
  localparam int RECIP_SH = 9;

  typedef logic signed [DEV_W-1:0] dev_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  function automatic dev_t div3_trunc(input acc_t s);
    logic [ACC_W-1:0]          mag;
    logic [ACC_W+RECIP_SH-1:0] prod;
    logic [DEV_W-1:0]          q;
    mag  = s[ACC_W-1] ? ACC_W'(-s) : ACC_W'(s);
    prod = (ACC_W+RECIP_SH)'(mag) * (ACC_W+RECIP_SH)'(RECIP);
    q    = DEV_W'(prod >> RECIP_SH);
    return s[ACC_W-1] ? dev_t'(-q) : dev_t'(q);
  endfunction
endpackage

// File: rtl/pps_period_meter.sv
module pps_period_meter
  import pps_avg_pkg::*;
#(
  parameter int NOMINAL = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pps_i,
  output logic s1_strobe,
  output logic s1_valid,
  output logic s1_ok,
  output dev_t s1_dev,
  output logic missing
);
  localparam int MISS_LIM = NOMINAL + NOMINAL / 2;
  localparam int CNT_W    = $clog2(MISS_LIM + 1);
  localparam int LO_LIM   = (NOMINAL + DEV_MIN > 0) ? NOMINAL + DEV_MIN : 0;
  localparam int HI_LIM   = NOMINAL + DEV_MAX;
  localparam logic [DEV_W-1:0] NOM_LOW = DEV_W'(NOMINAL % (1 << DEV_W));

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             miss_q, miss_d;
  logic             cnt_en;
  logic             in_win;

  assign cnt_en = pps_i | armed_q;
  assign in_win = (int'(cnt_q) >= LO_LIM) && (int'(cnt_q) <= HI_LIM);

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    miss_d  = miss_q;
    if (pps_i) begin
      cnt_d   = CNT_W'(1);
      armed_d = 1'b1;
      miss_d  = 1'b0;
    end else if (armed_q) begin
      if (int'(cnt_q) == MISS_LIM) begin
        armed_d = 1'b0;
        miss_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      miss_q  <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      miss_q  <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_strobe <= 1'b0;
      s1_valid  <= 1'b0;
      s1_ok     <= 1'b0;
      s1_dev    <= '0;
    end else begin
      s1_strobe <= pps_i;
      s1_valid  <= pps_i & armed_q;
      s1_ok     <= in_win;
      if (pps_i) s1_dev <= dev_t'(cnt_q[DEV_W-1:0] - NOM_LOW);
    end
  end

  assign missing = miss_q;
endmodule

// File: rtl/pps_dev_accum.sv
module pps_dev_accum
  import pps_avg_pkg::*;
#(
  parameter int GROUP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s1_strobe,
  input  logic s1_valid,
  input  logic s1_ok,
  input  dev_t s1_dev,
  output logic s2_strobe,
  output logic reject,
  output logic go,
  output acc_t sum
);
  localparam int N_W = $clog2(GROUP);

  logic [N_W-1:0] n_q, n_d;
  acc_t           acc_q, acc_d, sum_d, acc_plus;
  logic           go_d, take;

  assign take     = s1_valid & s1_ok;
  assign acc_plus = acc_q + acc_t'(s1_dev);

  always_comb begin
    n_d   = n_q;
    acc_d = acc_q;
    sum_d = sum;
    go_d  = 1'b0;
    if (take) begin
      if (int'(n_q) == GROUP - 1) begin
        n_d   = '0;
        acc_d = '0;
        sum_d = acc_plus;
        go_d  = 1'b1;
      end else begin
        n_d   = n_q + N_W'(1);
        acc_d = acc_plus;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q       <= '0;
      acc_q     <= '0;
      sum       <= '0;
      go        <= 1'b0;
      reject    <= 1'b0;
      s2_strobe <= 1'b0;
    end else begin
      if (take) begin
        n_q   <= n_d;
        acc_q <= acc_d;
        sum   <= sum_d;
      end
      go        <= go_d;
      reject    <= s1_valid & ~s1_ok;
      s2_strobe <= s1_strobe;
    end
  end
endmodule

// File: rtl/pps_div3.sv
module pps_div3
  import pps_avg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  acc_t sum,
  output dev_t quot,
  output logic have
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot <= '0;
      have <= 1'b0;
    end else if (go) begin
      quot <= div3_trunc(sum);
      have <= 1'b1;
    end
  end
endmodule

// File: rtl/pps_dev_avg.sv
module pps_dev_avg
  import pps_avg_pkg::*;
#(
  parameter int NOMINAL = 10_000_000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pps_i,
  output logic signed [DEV_W-1:0] corr_word_o,
  output logic                    corr_valid_o,
  output logic                    avg_ready_o,
  output logic                    reject_o,
  output logic                    missing_o
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic s1_strobe, s1_valid, s1_ok, s2_strobe, go, have, tick3;
  dev_t s1_dev, quot;
  acc_t sum;

  pps_period_meter #(.NOMINAL(NOMINAL)) i_meter (
    .clk(clk), .rst_n(rst_int_n), .pps_i(pps_i),
    .s1_strobe(s1_strobe), .s1_valid(s1_valid), .s1_ok(s1_ok),
    .s1_dev(s1_dev), .missing(missing_o)
  );

  pps_dev_accum #(.GROUP(3)) i_accum (
    .clk(clk), .rst_n(rst_int_n), .s1_strobe(s1_strobe),
    .s1_valid(s1_valid), .s1_ok(s1_ok), .s1_dev(s1_dev),
    .s2_strobe(s2_strobe), .reject(reject_o), .go(go), .sum(sum)
  );

  pps_div3 i_div (
    .clk(clk), .rst_n(rst_int_n), .go(go), .sum(sum),
    .quot(quot), .have(have)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) tick3 <= 1'b0;
    else            tick3 <= s2_strobe;
  end

  assign corr_word_o  = quot;
  assign avg_ready_o  = have;
  assign corr_valid_o = tick3 & have;
endmodule

// File: rtl/pps_dev_avg_chk.sv
module pps_dev_avg_chk
  import pps_avg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       pps_i,
  input logic [7:0] corr_word_o,
  input logic       corr_valid_o,
  input logic       avg_ready_o,
  input logic       reject_o,
  input logic       missing_o
);
  a_r6_valid_needs_avg: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid_o |-> avg_ready_o);
  a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    avg_ready_o |=> avg_ready_o);
  a_r5_word_moves_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(corr_word_o) |-> corr_valid_o);
  a_r7_missing_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (missing_o && !pps_i) |=> missing_o);
  a_r7_missing_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pps_i |=> !missing_o);
  a_r7_word_held_when_missing: assert property (@(posedge clk) disable iff (!rst_n)
    missing_o |-> $stable(corr_word_o));
  a_r4_reject_not_with_missing: assert property (@(posedge clk) disable iff (!rst_n)
    missing_o |-> !reject_o);
endmodule

bind pps_dev_avg pps_dev_avg_chk i_chk (
  .clk(clk), .rst_n(rst_n), .pps_i(pps_i), .corr_word_o(corr_word_o),
  .corr_valid_o(corr_valid_o), .avg_ready_o(avg_ready_o),
  .reject_o(reject_o), .missing_o(missing_o)
);

// File: tb/test_pps_dev_avg.sv
module test_pps_dev_avg;
  localparam int CLK_PERIOD = 10;
  localparam int NOM = 300;
  localparam int NROW = 19;
  // period, expected reject, expected valid, expected word, expected ready
  localparam int VEC [NROW][5] = '{
    '{10, 0, 0, 0, 0}, '{305, 0, 0, 0, 0}, '{310, 0, 0, 0, 0},
    '{301, 0, 1, 5, 1}, '{428, 1, 1, 5, 1}, '{172, 0, 1, 5, 1},
    '{427, 0, 1, 5, 1}, '{171, 1, 1, 5, 1}, '{299, 0, 1, 0, 1},
    '{298, 0, 1, 0, 1}, '{298, 0, 1, 0, 1}, '{300, 0, 1, -1, 1},
    '{172, 0, 1, -1, 1}, '{172, 0, 1, -1, 1}, '{172, 0, 1, -128, 1},
    '{427, 0, 1, -128, 1}, '{427, 0, 1, -128, 1}, '{427, 0, 1, 127, 1},
    '{300, 0, 1, 127, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pps = 1'b0;
  logic signed [7:0] word;
  logic valid, ready, rej, miss;
  int n_checks = 0;
  int n_fail = 0;
  int consumed = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pps_dev_avg #(.NOMINAL(NOM)) i_pps_dev_avg (
    .clk(clk), .rst_n(rst_n), .pps_i(pps), .corr_word_o(word),
    .corr_valid_o(valid), .avg_ready_o(ready), .reject_o(rej), .missing_o(miss)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input bit v);
    @(negedge clk);
    pps = v;
  endtask

  // strobe closing a period of p cycles, then observe cycles t+1..t+3
  task automatic second(input int p, input int erej, input int ecv, input int ew,
                        input int erdy, input string tag);
    for (int i = 0; i < p - 1 - consumed; i++) tick(1'b0);
    tick(1'b1);
    tick(1'b0);
    check(valid == 1'b0, {tag, " R6 no early pulse"}, valid, 0);
    tick(1'b0);
    check(rej == erej[0], {tag, " R3 R4 reject"}, rej, erej);
    tick(1'b0);
    check(valid == ecv[0], {tag, " R6 valid"}, valid, ecv);
    if (ecv != 0) check(int'(word) == ew, {tag, " R5 R8 word"}, int'(word), ew);
    check(ready == erdy[0], {tag, " R6 ready"}, ready, erdy);
    consumed = 3;
  endtask

  initial begin
    repeat (3) tick(1'b0);
    check(valid == 0 && rej == 0 && miss == 0 && ready == 0 && word == 0,
          "R1 reset state", {valid, rej, miss, ready}, 0);
    rst_n = 1'b1;
    repeat (4) tick(1'b0);
    check(ready == 0 && valid == 0, "R1 after release", ready, 0);

    for (int r = 0; r < NROW; r++)
      second(VEC[r][0], VEC[r][1], VEC[r][2], VEC[r][3], VEC[r][4],
             (r == 0) ? "R2 first" : "table");

    // timeout: limit 450 cycles since last strobe; now at t+3
    for (int i = 0; i < 447; i++) tick(1'b0);
    check(miss == 1'b0, "R7 not yet missing", miss, 0);
    tick(1'b0);
    check(miss == 1'b1, "R7 missing rises", miss, 1);
    repeat (20) tick(1'b0);
    check(miss == 1'b1 && int'(word) == 127, "R7 held", int'(word), 127);
    consumed = 0;
    second(8, 0, 1, 127, 1, "R2 R7 restart");
    check(miss == 1'b0, "R7 cleared", miss, 0);
    second(303, 0, 1, 127, 1, "R7 partial kept");
    second(306, 0, 1, 3, 1, "R7 group completes");

    // reset mid-run
    rst_n = 1'b0;
    tick(1'b0);
    tick(1'b0);
    check(ready == 0 && valid == 0 && word == 0 && miss == 0, "R1 reset again",
          ready, 0);
    rst_n = 1'b1;
    repeat (4) tick(1'b0);
    consumed = 0;
    second(6, 0, 0, 0, 0, "R2 first after reset");
    second(300, 0, 0, 0, 0, "R6 none before avg");
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule